// File: doc/BRIEF.md
# SMRAM Access Protection Decoder

This block sits on the path from the processor to memory. For each request it picks a target, either DRAM or the system bus, and decides whether the request may go ahead. The decision depends on whether the processor is in system management mode (SMM).

Two structures guard the SMM memory:

- **Legacy window.** The fixed window at 0xA0000–0xBFFFF is routed by mode. An open bit lets non-SMM code reach the DRAM behind it. A sticky lock bit freezes that choice until reset.
- **Protected range.** A programmable range is described by a base register and a mask register. It hides the main SMM region from code outside SMM. Every hit in the range, from either mode, is flagged uncacheable.

All routing and protection outputs are combinational in the request cycle. Only the violation pulse is registered. Software programs the three configuration registers through a simple write port.

Top module: `smram_gatekeeper`

## Requirements
- R1: After reset the open bit, the lock bit and the range valid bit are all 0. A non-SMM access to the legacy window then goes to the system bus, and no access is blocked or marked uncacheable.
- R2: An access to the legacy window (0xA0000 through 0xBFFFF inclusive) made in SMM is routed to DRAM (`route_dram`=1), whatever the open bit holds.
- R3: A non-SMM access to the legacy window goes to the system bus (`route_dram`=0) when the open bit is 0, and to DRAM when it is 1. Addresses outside the window, including 0x9FFFF and 0xC0000, always go to DRAM.
- R4: The control register is write select 0, with bit 0 = open and bit 1 = lock. Lock can only be written from 0 to 1. Once lock is 1, every write to select 0 is dropped until reset.
- R5: The base register is write select 1 and the mask register is write select 2. Both take address bits [ADDR_W-1:12] from the same bit positions of the write data. Mask bit 11 is the valid bit. Base bits [2:0] carry a memory type that has no effect. An address hits when (addr & mask) == (base & mask) over bits [ADDR_W-1:12].
- R6: While valid is 1, a range hit asserts `req_uncached` in either mode, and also asserts `req_blocked` when not in SMM. While valid is 0, neither flag is raised.
- R7: A blocked read asserts `rd_all_ones`, meaning the returned data is forced to all ones. A blocked write asserts `wr_discard`. Neither flag is raised for an unblocked access.
- R8: `viol_pulse` is high for exactly the cycle after each blocked request, and low otherwise.
- R9: Route, block, uncacheable and data-handling outputs follow the request inputs in the same cycle, with no register on the path.
- R10: A configuration write takes effect from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Requester is in SMM |
| req_addr | input | ADDR_W | Physical request address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 mask |
| cfg_wdata | input | ADDR_W | Configuration write data |
| route_dram | output | 1 | 1 = DRAM, 0 = system bus |
| req_blocked | output | 1 | Request denied |
| req_uncached | output | 1 | Request falls in the protected range; treat as uncacheable |
| rd_all_ones | output | 1 | Blocked read; return all ones |
| wr_discard | output | 1 | Blocked write; drop it |
| viol_pulse | output | 1 | Registered one-cycle violation pulse |

## Verification
The vector table uses a protected range of 0xBD000000 with mask 0xFF800000. It probes both edges of the legacy window, the addresses just outside it, both edges of the protected range and its neighbours, in each mode and for reads and writes. This separates window routing from range blocking, and separates the uncacheable flag from the block flag.

Directed sequences change the open bit, then set lock with open both 0 and 1 and try to undo it. This shows that the frozen routing comes from the lock and not from the open value alone. A cleared valid bit shows that a matching address on its own has no effect. A lone blocked request, followed by idle cycles, fixes the cycle in which the violation pulse appears and the cycle in which it ends.

// File: rtl/smram_guard_pkg.sv
// Shared constants and the register-select type for the SMRAM access decoder.
package smram_guard_pkg;
    typedef enum logic [1:0] {
        CSEL_CTRL = 2'd0,
        CSEL_BASE = 2'd1,
        CSEL_MASK = 2'd2
    } cfg_sel_e;

    localparam int CTRL_OPEN_BIT  = 0;
    localparam int CTRL_LOCK_BIT  = 1;
    localparam int MASK_VALID_BIT = 11;
    localparam int RANGE_LSB      = 12;

    localparam logic [19:0] LEGACY_LO = 20'hA0000;
    localparam logic [19:0] LEGACY_HI = 20'hBFFFF;
endpackage

// File: rtl/smram_cfg_regs.sv
// Configuration registers: legacy-window control (open, sticky lock) and the
// protected-range base/mask pair.
// Assumes: ADDR_W > 12; writes to select 3 are ignored; the memory-type bits
// of the base word are not stored.
module smram_cfg_regs
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int RW    = ADDR_W - RANGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              open_o,
    output logic              lock_o,
    output logic [RW-1:0]     base_o,
    output logic [RW-1:0]     mask_o,
    output logic              valid_o
);
    // Bits of the write word that no register keeps (memory type, spare).
    wire unused_wbits = ^cfg_wdata[MASK_VALID_BIT-1:CTRL_LOCK_BIT+1];

    // Control register: frozen once lock is set; lock clears only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            lock_o <= 1'b0;
        end else if (cfg_we && cfg_sel_e'(cfg_sel) == CSEL_CTRL && !lock_o) begin
            open_o <= cfg_wdata[CTRL_OPEN_BIT];
            lock_o <= cfg_wdata[CTRL_LOCK_BIT];
        end
    end

    // Range base and mask/valid registers: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            mask_o  <= '0;
            valid_o <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CSEL_BASE: base_o <= cfg_wdata[ADDR_W-1:RANGE_LSB];
                CSEL_MASK: begin
                    mask_o  <= cfg_wdata[ADDR_W-1:RANGE_LSB];
                    valid_o <= cfg_wdata[MASK_VALID_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smram_legacy_decode.sv
// Legacy SMM window routing: SMM accesses or an open window go to DRAM;
// closed non-SMM accesses go to the system bus; everything else goes to DRAM.
// Assumes: ADDR_W > 20.
module smram_legacy_decode
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic              open_en,
    output logic              in_window,
    output logic              to_dram
);
    // Window compare and route choice.
    always_comb begin
        in_window = (addr >= ADDR_W'(LEGACY_LO)) && (addr <= ADDR_W'(LEGACY_HI));
        to_dram   = !in_window || smm || open_en;
    end
endmodule

// File: rtl/smram_range_check.sv
// Base/mask range match over the address bits above the 4 KiB granule.
// Assumes: mask bits set to 1 are compared, bits set to 0 are ignored.
module smram_range_check
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int RW    = ADDR_W - RANGE_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [RW-1:0]     base,
    input  logic [RW-1:0]     mask,
    input  logic              valid,
    output logic              hit
);
    // Below-granule address bits take no part in the match.
    wire unused_low = ^addr[RANGE_LSB-1:0];

    // Masked compare, gated by the valid bit.
    always_comb begin
        hit = valid && ((addr[ADDR_W-1:RANGE_LSB] & mask) == (base & mask));
    end
endmodule

// File: rtl/smram_gatekeeper.sv
// Top level: combines legacy-window routing with protected-range checks,
// produces block, uncacheable and data-handling flags in the request cycle,
// and registers a one-cycle violation pulse.
// Assumes: synchronous active-low reset; outputs other than route_dram are
// qualified by req_valid.
module smram_gatekeeper
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              route_dram,
    output logic              req_blocked,
    output logic              req_uncached,
    output logic              rd_all_ones,
    output logic              wr_discard,
    output logic              viol_pulse
);
    localparam int RW = ADDR_W - RANGE_LSB;

    logic          ctl_open, ctl_lock, rng_valid, rng_hit, win_hit;
    logic [RW-1:0] rng_base, rng_mask;

    smram_cfg_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .open_o(ctl_open), .lock_o(ctl_lock),
        .base_o(rng_base), .mask_o(rng_mask), .valid_o(rng_valid)
    );

    smram_legacy_decode #(.ADDR_W(ADDR_W)) legacy_i (
        .addr(req_addr), .smm(req_smm), .open_en(ctl_open),
        .in_window(win_hit), .to_dram(route_dram)
    );

    smram_range_check #(.ADDR_W(ADDR_W)) range_i (
        .addr(req_addr), .base(rng_base), .mask(rng_mask),
        .valid(rng_valid), .hit(rng_hit)
    );

    // Per-request protection flags.
    always_comb begin
        req_uncached = req_valid && rng_hit;
        req_blocked  = req_uncached && !req_smm;
        rd_all_ones  = req_blocked && !req_write;
        wr_discard   = req_blocked && req_write;
    end

    // Violation pulse, one cycle after each blocked request.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_pulse <= 1'b0;
        else        viol_pulse <= req_blocked;
    end
endmodule

// File: rtl/smram_guard_checker.sv
// Assertion checker for smram_gatekeeper, attached by bind.
module smram_guard_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_smm,
    input logic [ADDR_W-1:0] req_addr,
    input logic              route_dram,
    input logic              req_blocked,
    input logic              req_uncached,
    input logic              rd_all_ones,
    input logic              wr_discard,
    input logic              viol_pulse,
    input logic              ctl_open,
    input logic              ctl_lock
);
    logic in_win;
    assign in_win = (req_addr >= ADDR_W'(20'hA0000)) && (req_addr <= ADDR_W'(20'hBFFFF));

    a_r2_smm_window_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_smm && in_win) |-> route_dram);
    a_r3_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> route_dram);
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_lock |=> ctl_lock);
    a_r4_open_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_lock |=> $stable(ctl_open));
    a_r6_smm_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        req_smm |-> !req_blocked);
    a_r6_block_is_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        req_blocked |-> req_uncached);
    a_r7_ones_on_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_all_ones |-> (req_blocked && !req_write));
    a_r7_discard_on_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_discard |-> (req_blocked && req_write));
    a_r8_pulse_follows_block: assert property (@(posedge clk) disable iff (!rst_n)
        req_blocked |=> viol_pulse);
    a_r8_no_pulse_without_block: assert property (@(posedge clk) disable iff (!rst_n)
        !req_blocked |=> !viol_pulse);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_uncached);
endmodule

bind smram_gatekeeper smram_guard_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_smm(req_smm), .req_addr(req_addr), .route_dram(route_dram),
    .req_blocked(req_blocked), .req_uncached(req_uncached),
    .rd_all_ones(rd_all_ones), .wr_discard(wr_discard),
    .viol_pulse(viol_pulse), .ctl_open(ctl_open), .ctl_lock(ctl_lock)
);

// File: tb/smram_gatekeeper_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed reset/lock/pulse tests.
module smram_gatekeeper_tb_top;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_smm = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic route_dram, req_blocked, req_uncached, rd_all_ones, wr_discard, viol_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    smram_gatekeeper #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_smm(req_smm), .req_addr(req_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .route_dram(route_dram), .req_blocked(req_blocked),
        .req_uncached(req_uncached), .rd_all_ones(rd_all_ones),
        .wr_discard(wr_discard), .viol_pulse(viol_pulse)
    );

    // {smm, write, addr[31:0], exp_route, exp_block, exp_uncached}
    // Range: base 0xBD000000 (memtype 6 in low bits), mask 0xFF800000, valid.
    localparam int NV = 11;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h000A0000, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 32'h000BFFFF, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 32'h0009FFFF, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 32'h000C0000, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 32'h000A0000, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b1, 32'h000B8000, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 32'hBD000000, 1'b1, 1'b1, 1'b1},
        {1'b0, 1'b1, 32'hBD7FFFFF, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b0, 32'hBD400000, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b0, 32'hBD800000, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 32'hBCFFFFFF, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request at a falling edge; outputs are sampled 1 ns later.
    task automatic req(input logic smm, input logic wr, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_smm = smm; req_write = wr; req_addr = a;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_smm = 1'b0; req_write = 1'b0; req_addr = '0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state, closed window and no range protection
        req(1'b0, 1'b0, 32'h000A0000);
        chk("R1 route closed after reset", route_dram, 1'b0);
        req(1'b0, 1'b0, 32'hBD000000);
        chk("R1 no block after reset", req_blocked, 1'b0);
        chk("R1 no uncached after reset", req_uncached, 1'b0);
        idle();
        chk("R1 no pulse after reset", viol_pulse, 1'b0);

        // R5: program range; base carries memtype 6 in low bits
        cfg_write(2'd1, 32'hBD000006);
        cfg_write(2'd2, 32'hFF800800);

        // Vector walk: R2 R3 R5 R6 R7 R9, all sampled in the request cycle
        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            req(v[36], v[35], v[34:3]);
            chk($sformatf("R2/R3 route vec%0d", i), route_dram, v[2]);
            chk($sformatf("R6 block vec%0d", i), req_blocked, v[1]);
            chk($sformatf("R6 uncached vec%0d", i), req_uncached, v[0]);
            chk($sformatf("R7 ones vec%0d", i), rd_all_ones, v[1] & ~v[35]);
            chk($sformatf("R7 discard vec%0d", i), wr_discard, v[1] & v[35]);
        end
        idle();

        // R8: one blocked request -> pulse in the next cycle only
        idle();
        req(1'b0, 1'b0, 32'hBD001000);
        chk("R9 same-cycle block", req_blocked, 1'b1);
        idle();
        chk("R8 pulse after block", viol_pulse, 1'b1);
        idle();
        chk("R8 pulse ends", viol_pulse, 1'b0);

        // R6: valid cleared, matching address no longer protected
        cfg_write(2'd2, 32'hFF800000);
        req(1'b0, 1'b0, 32'hBD000000);
        chk("R6 invalid no block", req_blocked, 1'b0);
        chk("R6 invalid no uncached", req_uncached, 1'b0);

        // R3 R10: open the window
        cfg_write(2'd0, 32'h1);
        req(1'b0, 1'b0, 32'h000B0000);
        chk("R3 R10 open routes dram", route_dram, 1'b1);

        // R4: lock with open=1, then try to close and unlock
        cfg_write(2'd0, 32'h3);
        cfg_write(2'd0, 32'h0);
        req(1'b0, 1'b0, 32'h000B0000);
        chk("R4 locked open stays", route_dram, 1'b1);
        idle();

        // R1: reset clears lock and open
        do_reset();
        req(1'b0, 1'b0, 32'h000A0000);
        chk("R1 reset clears lock/open", route_dram, 1'b0);

        // R4: lock with open=0, attempt to open is dropped
        cfg_write(2'd0, 32'h2);
        cfg_write(2'd0, 32'h1);
        req(1'b0, 1'b0, 32'h000A0000);
        chk("R4 locked closed stays", route_dram, 1'b0);
        req(1'b1, 1'b0, 32'h000A0000);
        chk("R2 smm dram while locked", route_dram, 1'b1);
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule